// File: doc/BRIEF.md
# Scanned Key Matrix Encoder

This block reads a switch matrix of four columns by four or five rows and turns one closed key into a small binary code. It pulls one column low at a time. The column advances on a scan-rate tick enable. It watches the active-low row inputs, which are assumed to be pulled high and already synchronised to the system clock. When a row reads low, the scan stops on the current column and every other row is ignored. The block then checks that the key stays closed for a set number of scan ticks before it accepts it.

An accepted key is written into a last-key register and a data-valid flag goes high. The flag drops as soon as that key opens, even if another key is already closed. Before scanning resumes, the open state must also last a full debounce period. This gives strict two-key roll-over: a second key held during the first is encoded only after the first is released and its release debounce has run out. The code outputs are meant for a shared bus. A separate drive-enable output follows an active-low output enable and stands in for three-state pins.

Top module: `keymatrix_enc`

## Requirements
- R1: After reset the column index is 0. The column outputs drive exactly one column low at a time (colN[c] = 0 for column c). While no key is seen, the index steps 0,1,2,3,0 on each cycle with scanTick high and holds on cycles with scanTick low.
- R2: Once any row reads low in the driven column, the column stops advancing. Only the captured row is watched until scanning resumes, and keys in other rows or columns have no effect on the outputs.
- R3: The key code is 4 × row + column. Bits [1:0] hold the column index and the upper bits hold the row index. With NUM_ROWS = 5 the code is 5 bits wide, and bit 4 is set only for keys on row 4.
- R4: A closure is accepted on the clock edge after the debounce counter reaches DEBOUNCE_TICKS. The counter starts at 0 on the capture edge and counts scanTick cycles while the row stays low. On acceptance the code is latched and dataValid rises in the same cycle. With scanTick always high, dataValid rises after the fifth edge that sees the key (DEBOUNCE_TICKS = 3).
- R5: If the captured row goes high before acceptance, the debounce count is discarded and the block returns to scanning. A later closure needs a full new debounce period.
- R6: dataValid falls on the first edge that sees the accepted row high, even when another key is held.
- R7: After a release, scanning resumes only after the row has stayed high for DEBOUNCE_TICKS ticks. A row low during this time restarts the count, and the column stays frozen throughout.
- R8: The last-key register keeps the accepted code after release until the next acceptance. codeDrive is high exactly while outEnN is low.
- R9: Synchronous reset clears the key code to 0, dataValid to 0 and the column index to 0.
- R10: A second key held while the first is accepted is latched only after the first is released and the release debounce ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| scanTick | input | 1 | Scan-rate enable for the column counter and debounce counter |
| rowN | input | NUM_ROWS | Row inputs, low when a key in the driven column is closed |
| outEnN | input | 1 | Output enable for the code, active low |
| colN | output | 4 | Column drives, a 0 bit means pull that column low |
| keyCode | output | CODE_W | Last accepted key code |
| codeDrive | output | 1 | High while keyCode should drive the bus |
| dataValid | output | 1 | High while the accepted key is held |

## Verification
Checked on every cycle by assertions:
- exactly one column is low;
- the column is frozen while dataValid is high;
- the key code changes only in a cycle where dataValid rises;
- dataValid rises only after the captured row was low;
- the debounce counter never passes its limit;
- codeDrive is the inverse of outEnN.

Only the bench scenarios can show:
- the exact cycle of acceptance;
- the restart after a press bounce or a release bounce;
- the code value for each matrix position, including the fifth-row bit;
- the strict roll-over order with two keys held.

// File: rtl/keymatrix_pkg.sv
package keymatrix_pkg;

  typedef enum logic [1:0] {
    ST_SCAN      = 2'd0,
    ST_DEB_PRESS = 2'd1,
    ST_HELD      = 2'd2,
    ST_DEB_REL   = 2'd3
  } kmState_e;

  typedef struct packed {
    logic colAdvance;
    logic capture;
    logic cntClear;
    logic cntInc;
    logic latchCode;
  } kmStrobe_t;

endpackage

// File: rtl/keymatrix_dp.sv
module keymatrix_dp
  import keymatrix_pkg::*;
#(
  parameter int NUM_ROWS       = 5,
  parameter int DEBOUNCE_TICKS = 3,
  parameter int ROW_W          = (NUM_ROWS > 4) ? 3 : 2,
  parameter int CODE_W         = ROW_W + 2
) (
  input  logic                clk,
  input  logic                rst,
  input  kmStrobe_t           strb,
  input  logic [NUM_ROWS-1:0] rowN,
  output logic [3:0]          colN,
  output logic                rowHit,
  output logic                capRowLow,
  output logic                cntDone,
  output logic [CODE_W-1:0]   keyCode
);

  localparam int CNT_W = (DEBOUNCE_TICKS < 1) ? 1 : $clog2(DEBOUNCE_TICKS + 1);
  localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(DEBOUNCE_TICKS);

  logic [1:0]        colIdxQ;
  logic [ROW_W-1:0]  capRowQ;
  logic [ROW_W-1:0]  hitRow;
  logic [CNT_W-1:0]  cntQ;
  logic [CODE_W-1:0] codeQ;

  // lowest-numbered low row wins
  always_comb begin
    hitRow = '0;
    for (int r = NUM_ROWS - 1; r >= 0; r--) begin
      if (!rowN[r]) hitRow = ROW_W'(r);
    end
  end

  assign rowHit = ~&rowN;

  always_comb begin
    capRowLow = 1'b0;
    for (int r = 0; r < NUM_ROWS; r++) begin
      if (capRowQ == ROW_W'(r)) capRowLow = !rowN[r];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      colIdxQ <= '0;
      capRowQ <= '0;
    end else begin
      if (strb.colAdvance) colIdxQ <= colIdxQ + 2'd1;
      if (strb.capture)    capRowQ <= hitRow;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)               cntQ <= '0;
    else if (strb.cntClear) cntQ <= '0;
    else if (strb.cntInc)   cntQ <= cntQ + 1'b1;
  end

  assign cntDone = (cntQ == CNT_LIM);

  always_ff @(posedge clk) begin
    if (rst)                codeQ <= '0;
    else if (strb.latchCode) codeQ <= {capRowQ, colIdxQ};
  end

  assign keyCode = codeQ;
  assign colN    = ~(4'b0001 << colIdxQ);

  assert_one_column_R1: assert property (@(posedge clk) disable iff (rst)
    $countones(~colN) == 1);

  assert_cnt_in_range_R4: assert property (@(posedge clk) disable iff (rst)
    cntQ <= CNT_LIM);

endmodule

// File: rtl/keymatrix_ctl.sv
module keymatrix_ctl
  import keymatrix_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      scanTick,
  input  logic      rowHit,
  input  logic      capRowLow,
  input  logic      cntDone,
  output kmStrobe_t strb,
  output logic      dataValid
);

  kmState_e stateQ, stateNext;
  logic     davQ;

  always_comb begin
    strb      = '0;
    stateNext = stateQ;
    unique case (stateQ)
      ST_SCAN: begin
        if (rowHit) begin
          strb.capture  = 1'b1;
          strb.cntClear = 1'b1;
          stateNext     = ST_DEB_PRESS;
        end else if (scanTick) begin
          strb.colAdvance = 1'b1;
        end
      end
      ST_DEB_PRESS: begin
        if (!capRowLow) begin
          strb.cntClear = 1'b1;
          stateNext     = ST_SCAN;
        end else if (cntDone) begin
          strb.latchCode = 1'b1;
          stateNext      = ST_HELD;
        end else if (scanTick) begin
          strb.cntInc = 1'b1;
        end
      end
      ST_HELD: begin
        if (!capRowLow) begin
          strb.cntClear = 1'b1;
          stateNext     = ST_DEB_REL;
        end
      end
      ST_DEB_REL: begin
        if (capRowLow) begin
          strb.cntClear = 1'b1;
        end else if (cntDone) begin
          stateNext = ST_SCAN;
        end else if (scanTick) begin
          strb.cntInc = 1'b1;
        end
      end
      default: stateNext = ST_SCAN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ <= ST_SCAN;
      davQ   <= 1'b0;
    end else begin
      stateQ <= stateNext;
      davQ   <= (stateNext == ST_HELD);
    end
  end

  assign dataValid = davQ;

  assert_accept_needs_row_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(davQ) |-> $past(capRowLow));

endmodule

// File: rtl/keymatrix_enc.sv
module keymatrix_enc
  import keymatrix_pkg::*;
#(
  parameter int NUM_ROWS       = 5,
  parameter int DEBOUNCE_TICKS = 3,
  parameter int ROW_W          = (NUM_ROWS > 4) ? 3 : 2,
  parameter int CODE_W         = ROW_W + 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                scanTick,
  input  logic [NUM_ROWS-1:0] rowN,
  input  logic                outEnN,
  output logic [3:0]          colN,
  output logic [CODE_W-1:0]   keyCode,
  output logic                codeDrive,
  output logic                dataValid
);

  kmStrobe_t strb;
  logic      rowHit, capRowLow, cntDone;

  keymatrix_ctl i_ctl (
    .clk       (clk),
    .rst       (rst),
    .scanTick  (scanTick),
    .rowHit    (rowHit),
    .capRowLow (capRowLow),
    .cntDone   (cntDone),
    .strb      (strb),
    .dataValid (dataValid)
  );

  keymatrix_dp #(
    .NUM_ROWS       (NUM_ROWS),
    .DEBOUNCE_TICKS (DEBOUNCE_TICKS),
    .ROW_W          (ROW_W),
    .CODE_W         (CODE_W)
  ) i_dp (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .rowN      (rowN),
    .colN      (colN),
    .rowHit    (rowHit),
    .capRowLow (capRowLow),
    .cntDone   (cntDone),
    .keyCode   (keyCode)
  );

  assign codeDrive = !outEnN;

  assert_drive_follows_enable_R8: assert property (@(posedge clk) disable iff (rst)
    codeDrive != outEnN);

  assert_column_frozen_R2: assert property (@(posedge clk) disable iff (rst)
    dataValid |=> $stable(colN));

  assert_code_only_on_accept_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable(keyCode) |-> $rose(dataValid));

endmodule

// File: tb/test_keymatrix_enc.sv
`timescale 1ns/1ps
module test_keymatrix_enc;

  localparam int NUM_ROWS = 5;
  localparam int DEB      = 3;
  localparam int CODE_W   = 5;
  localparam int NKEYS    = NUM_ROWS * 4;

  localparam int NVEC = 8;
  localparam int VEC_KEY [NVEC] = '{0, 5, 10, 15, 19, 3, 16, 12};
  localparam logic [4:0] VEC_CODE [NVEC] =
    '{5'b00000, 5'b00101, 5'b01010, 5'b01111, 5'b10011, 5'b00011, 5'b10000, 5'b01100};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scanTick = 1'b1;
  logic outEnN = 1'b0;
  logic [NUM_ROWS-1:0] rowN;
  logic [3:0] colN;
  logic [CODE_W-1:0] keyCode;
  logic codeDrive, dataValid;
  logic [NKEYS-1:0] pressed = '0;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  // switch matrix: a row reads low when a closed key sits in a driven column
  always_comb begin
    for (int r = 0; r < NUM_ROWS; r++)
      rowN[r] = !(|(pressed[4*r +: 4] & ~colN));
  end

  keymatrix_enc #(.NUM_ROWS(NUM_ROWS), .DEBOUNCE_TICKS(DEB)) i_keymatrix_enc (
    .clk(clk), .rst(rst), .scanTick(scanTick), .rowN(rowN), .outEnN(outEnN),
    .colN(colN), .keyCode(keyCode), .codeDrive(codeDrive), .dataValid(dataValid)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    pressed = '0;
    scanTick = 1'b1;
    outEnN = 1'b0;
    step(2);
    rst = 1'b0;
  endtask

  task automatic waitDav(output bit ok);
    ok = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (dataValid) begin
        ok = 1;
        break;
      end
    end
  endtask

  initial begin
    bit ok;
    doReset();
    // R9 reset state
    check("R9 colN", colN, 4'b1110);
    check("R9 dataValid", dataValid, 0);
    check("R9 keyCode", keyCode, 0);

    // R1 column walk and hold without tick
    step(1); check("R1 col1", colN, 4'b1101);
    step(1); check("R1 col2", colN, 4'b1011);
    scanTick = 1'b0;
    step(3); check("R1 hold", colN, 4'b1011);
    scanTick = 1'b1;
    step(1); check("R1 col3", colN, 4'b0111);
    step(1); check("R1 wrap", colN, 4'b1110);

    // table walk: R3 code per position
    for (int v = 0; v < NVEC; v++) begin
      pressed = '0;
      pressed[VEC_KEY[v]] = 1'b1;
      waitDav(ok);
      check("R3 accept", ok, 1);
      check("R3 code", keyCode, VEC_CODE[v]);
      check("R8 drive", codeDrive, 1);
      pressed = '0;
      step(1);
      check("R6 drop", dataValid, 0);
      check("R8 keep", keyCode, VEC_CODE[v]);
      step(10);
    end

    // R4 exact acceptance cycle
    doReset();
    pressed[0] = 1'b1;
    step(4); check("R4 early", dataValid, 0);
    step(1); check("R4 accept", dataValid, 1);
    check("R4 code", keyCode, 0);

    // R7 release bounce restarts, column frozen
    pressed = '0;
    step(1); check("R6 release", dataValid, 0);
    step(2);
    pressed[0] = 1'b1;
    step(1); check("R7 bounce", dataValid, 0);
    pressed = '0;
    step(4); check("R7 frozen", colN, 4'b1110);
    step(1); check("R7 resume", colN, 4'b1101);

    // R5 press bounce restarts debounce
    doReset();
    pressed[0] = 1'b1;
    step(3);
    pressed = '0;
    step(1);
    pressed[0] = 1'b1;
    step(1); check("R5 no early", dataValid, 0);
    step(3); check("R5 still", dataValid, 0);
    step(1); check("R5 accept", dataValid, 1);

    // R10 / R2 roll-over
    doReset();
    pressed[6] = 1'b1;
    waitDav(ok);
    check("R10 first", keyCode, 6);
    pressed[9] = 1'b1;
    step(6);
    check("R2 ignore dav", dataValid, 1);
    check("R2 ignore code", keyCode, 6);
    pressed[6] = 1'b0;
    step(1);
    check("R6 drop held", dataValid, 0);
    check("R8 last", keyCode, 6);
    waitDav(ok);
    check("R10 second", ok, 1);
    check("R10 code", keyCode, 9);

    // R8 output enable
    outEnN = 1'b1;
    step(1);
    check("R8 off", codeDrive, 0);
    check("R8 value", keyCode, 9);

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule